// File: doc/BRIEF.md
# Physical Register Readiness Scoreboard

This block tracks which physical registers hold a finished value and which queue entries are still waiting for their operands. It keeps one ready flag per physical register and a small table of waiting entries. Each entry records two source tags and a ready flag for each source. A dispatch writes one entry and may claim a destination register. A completion marks a register as produced and wakes every waiting source that names it. A squash mask removes entries from the table.

The block drives a per-entry all-ready vector. Downstream selection logic reads this vector to pick what to issue. A tag whose value is at or above the physical register count stands for a value the block does not track. Such a tag is treated as always available and never touches the flags. A dispatch samples the register flags when it is written, and it also sees a completion arriving in the same cycle. An instruction whose producer finished while it was in flight is therefore not left waiting forever.

Top module: `preg_wakeup_sb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every bit of `preg_ready`, `entry_valid` and `entry_ready` reads 0. This holds even for registers that would be architecturally ready.
- R2: A dispatch with `disp_dst_valid` high and a tracked destination tag clears that register's `preg_ready` bit in the next cycle. If a completion names the same register in the same cycle, the clear wins.
- R3: At dispatch, a tracked source whose `preg_ready` bit is already 1 is stored as ready in the entry at once. A tracked source whose bit is 0 is stored as waiting.
- R4: A completion with a tracked tag sets that register's `preg_ready` bit in the next cycle. In that same cycle it marks ready every source of every valid entry whose tag equals the completion tag.
- R5: A tag is tracked when its value is below NUM_PREGS (64), so 7-bit tag values 64 to 127 are untracked. An untracked source is stored as ready at dispatch. An untracked completion or destination leaves `preg_ready` unchanged and wakes no source.
- R6: `entry_ready[i]` is 1 exactly when entry i is valid and both of its sources are ready. Once it is 1, it stays 1 until the entry is squashed or written by a new dispatch.
- R7: A 1 in bit i of `squash_mask` makes entry i invalid in the next cycle, and later completions do not bring it back. If a dispatch writes the same slot in the same cycle, the dispatch wins and the new entry is valid.
- R8: When a completion and a dispatch whose source names the same tracked register occur in the same cycle, that source is stored as ready.
- R9: A dispatch into slot `disp_slot` sets `entry_valid` for that slot in the next cycle, overwriting whatever the slot held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_valid | input | 1 | A dispatch is presented this cycle |
| disp_slot | input | 4 | Table slot the dispatch writes |
| disp_src_a | input | 7 | First source tag |
| disp_src_b | input | 7 | Second source tag |
| disp_dst_valid | input | 1 | The dispatch claims a destination register |
| disp_dst | input | 7 | Destination tag |
| cmpl_valid | input | 1 | A completion is presented this cycle |
| cmpl_tag | input | 7 | Tag of the register the completion produced |
| squash_mask | input | 16 | One bit per slot; a 1 removes that entry |
| preg_ready | output | 64 | Ready flag of each physical register |
| entry_valid | output | 16 | Slot holds a live waiting entry |
| entry_ready | output | 16 | Slot is valid and all of its sources are ready |

## Verification
The bench targets the same-cycle collisions first, because each one fails in a distinct way:
- Completion meeting a dispatch source: a design without the bypass would leave that entry stuck, never ready.
- Completion meeting a destination claim: a design that let the set win would show a register as ready before its new producer has run.
- Squash meeting a dispatch into the same slot: getting the priority wrong would lose a freshly written entry.

It also sends tags just above the tracked range. A design that indexed the flags with the truncated tag would set or clear the wrong register, or leave an entry waiting on an untracked operand. Finally, it completes a squashed entry's source, which a faulty design would revive.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
    // Default geometry of the readiness scoreboard.
    localparam int unsigned SBW_NUM_PREGS   = 64;
    localparam int unsigned SBW_NUM_ENTRIES = 16;
    // Sources carried by each waiting entry.
    localparam int unsigned SBW_NUM_SRCS    = 2;
endpackage

// File: rtl/sbw_board.sv
// Per-register ready flags: one set port (completion) and one clear port
// (destination claim); the clear is applied after the set.
module sbw_board #(
    parameter int NUM_PREGS = 64,
    localparam int IDX_W = $clog2(NUM_PREGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [IDX_W-1:0]     set_idx,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx,
    output logic [NUM_PREGS-1:0] flags
);
    typedef struct packed {
        logic [NUM_PREGS-1:0] bits;
    } board_t;

    board_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en) st_d.bits[set_idx] = 1'b1;
        if (clr_en) st_d.bits[clr_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.bits;
endmodule

// File: rtl/sbw_slot.sv
// One waiting entry: source tags, per-source ready flags, valid.
module sbw_slot #(
    parameter int TAG_W    = 7,
    parameter int NUM_SRCS = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            kill,
    input  logic                            wr_en,
    input  logic [NUM_SRCS-1:0][TAG_W-1:0]  wr_tags,
    input  logic [NUM_SRCS-1:0]             wr_rdy,
    input  logic                            wake_en,
    input  logic [TAG_W-1:0]                wake_tag,
    output logic                            valid,
    output logic                            all_rdy
);
    typedef struct packed {
        logic                           valid;
        logic [NUM_SRCS-1:0][TAG_W-1:0] tags;
        logic [NUM_SRCS-1:0]            rdy;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kill) begin
            st_d.valid = 1'b0;
        end else if (st_q.valid && wake_en) begin
            for (int s = 0; s < NUM_SRCS; s++) begin
                if (st_q.tags[s] == wake_tag) st_d.rdy[s] = 1'b1;
            end
        end
        // A new dispatch overrides both squash and wakeup.
        if (wr_en) begin
            st_d.valid = 1'b1;
            st_d.tags  = wr_tags;
            st_d.rdy   = wr_rdy;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid   = st_q.valid;
    assign all_rdy = st_q.valid & (&st_q.rdy);
endmodule

// File: rtl/preg_wakeup_sb.sv
module preg_wakeup_sb
    import sbw_pkg::*;
#(
    parameter int NUM_PREGS   = SBW_NUM_PREGS,
    parameter int NUM_ENTRIES = SBW_NUM_ENTRIES,
    localparam int TAG_W  = $clog2(NUM_PREGS) + 1,
    localparam int SLOT_W = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_valid,
    input  logic [SLOT_W-1:0]      disp_slot,
    input  logic [TAG_W-1:0]       disp_src_a,
    input  logic [TAG_W-1:0]       disp_src_b,
    input  logic                   disp_dst_valid,
    input  logic [TAG_W-1:0]       disp_dst,
    input  logic                   cmpl_valid,
    input  logic [TAG_W-1:0]       cmpl_tag,
    input  logic [NUM_ENTRIES-1:0] squash_mask,
    output logic [NUM_PREGS-1:0]   preg_ready,
    output logic [NUM_ENTRIES-1:0] entry_valid,
    output logic [NUM_ENTRIES-1:0] entry_ready
);
    localparam int IDX_W    = $clog2(NUM_PREGS);
    localparam int NUM_SRCS = SBW_NUM_SRCS;
    localparam logic [TAG_W-1:0] TAG_LIMIT = TAG_W'(NUM_PREGS);

    // Tags at or above the register count are not tracked.
    logic cmpl_trk;
    logic dst_trk;
    assign cmpl_trk = cmpl_valid && (cmpl_tag < TAG_LIMIT);
    assign dst_trk  = disp_valid && disp_dst_valid && (disp_dst < TAG_LIMIT);

    sbw_board #(.NUM_PREGS(NUM_PREGS)) u_board (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (cmpl_trk),
        .set_idx (cmpl_tag[IDX_W-1:0]),
        .clr_en  (dst_trk),
        .clr_idx (disp_dst[IDX_W-1:0]),
        .flags   (preg_ready)
    );

    // Source readiness sampled at dispatch, with same-cycle completion bypass.
    logic [NUM_SRCS-1:0][TAG_W-1:0] disp_tags;
    logic [NUM_SRCS-1:0]            disp_rdy;
    assign disp_tags = {disp_src_b, disp_src_a};

    for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
        logic src_trk;
        logic src_flag;
        logic src_byp;
        assign src_trk  = disp_tags[s] < TAG_LIMIT;
        assign src_flag = preg_ready[disp_tags[s][IDX_W-1:0]];
        assign src_byp  = cmpl_trk && (cmpl_tag == disp_tags[s]);
        assign disp_rdy[s] = !src_trk || src_flag || src_byp;
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
        logic wr_hit;
        assign wr_hit = disp_valid && (disp_slot == SLOT_W'(e));
        sbw_slot #(.TAG_W(TAG_W), .NUM_SRCS(NUM_SRCS)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .kill     (squash_mask[e]),
            .wr_en    (wr_hit),
            .wr_tags  (disp_tags),
            .wr_rdy   (disp_rdy),
            .wake_en  (cmpl_trk),
            .wake_tag (cmpl_tag),
            .valid    (entry_valid[e]),
            .all_rdy  (entry_ready[e])
        );
    end
endmodule

// File: rtl/preg_wakeup_sb_chk.sv
module preg_wakeup_sb_chk #(
    parameter int NUM_PREGS   = 64,
    parameter int NUM_ENTRIES = 16,
    localparam int TAG_W  = $clog2(NUM_PREGS) + 1,
    localparam int SLOT_W = $clog2(NUM_ENTRIES),
    localparam int IDX_W  = $clog2(NUM_PREGS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   disp_valid,
    input logic [SLOT_W-1:0]      disp_slot,
    input logic                   disp_dst_valid,
    input logic [TAG_W-1:0]       disp_dst,
    input logic                   cmpl_valid,
    input logic [TAG_W-1:0]       cmpl_tag,
    input logic [NUM_ENTRIES-1:0] squash_mask,
    input logic [NUM_PREGS-1:0]   preg_ready,
    input logic [NUM_ENTRIES-1:0] entry_valid,
    input logic [NUM_ENTRIES-1:0] entry_ready
);
    localparam logic [TAG_W-1:0] LIM = TAG_W'(NUM_PREGS);

    logic [NUM_ENTRIES-1:0] disp_oh;
    logic                   dst_claim;
    assign disp_oh   = disp_valid ? (NUM_ENTRIES'(1) << disp_slot) : '0;
    assign dst_claim = disp_valid && disp_dst_valid && (disp_dst < LIM);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (preg_ready == '0 && entry_valid == '0));

    // R2
    a_r2_dst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dst_claim |=> !preg_ready[$past(disp_dst[IDX_W-1:0])]);

    // R4
    a_r4_cmpl_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_tag < LIM && !(dst_claim && disp_dst == cmpl_tag))
        |=> preg_ready[$past(cmpl_tag[IDX_W-1:0])]);

    // R5
    a_r5_untracked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cmpl_valid || cmpl_tag >= LIM) && !dst_claim) |=> $stable(preg_ready));

    // R6
    a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(entry_ready) & ~$past(squash_mask) & ~$past(disp_oh)
                   & ~entry_ready) == '0));

    // R7
    a_r7_squash_removes: assert property (@(posedge clk) disable iff (!rst_n)
        ((squash_mask & ~disp_oh) != '0)
        |=> ((entry_valid & $past(squash_mask & ~disp_oh)) == '0));

    // R9
    a_r9_disp_valid: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> entry_valid[$past(disp_slot)]);
endmodule

bind preg_wakeup_sb preg_wakeup_sb_chk #(
    .NUM_PREGS   (NUM_PREGS),
    .NUM_ENTRIES (NUM_ENTRIES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .disp_valid     (disp_valid),
    .disp_slot      (disp_slot),
    .disp_dst_valid (disp_dst_valid),
    .disp_dst       (disp_dst),
    .cmpl_valid     (cmpl_valid),
    .cmpl_tag       (cmpl_tag),
    .squash_mask    (squash_mask),
    .preg_ready     (preg_ready),
    .entry_valid    (entry_valid),
    .entry_ready    (entry_ready)
);

// File: tb/test_preg_wakeup_sb.sv
`timescale 1ns/1ps
module test_preg_wakeup_sb;
    localparam int NP = 64;
    localparam int NE = 16;
    localparam int TW = 7;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          disp_valid;
    logic [SW-1:0] disp_slot;
    logic [TW-1:0] disp_src_a, disp_src_b, disp_dst, cmpl_tag;
    logic          disp_dst_valid, cmpl_valid;
    logic [NE-1:0] squash_mask;
    logic [NP-1:0] preg_ready;
    logic [NE-1:0] entry_valid, entry_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Behavioural reference state.
    bit m_sb [NP];
    bit m_v  [NE];
    int m_tag[NE][2];
    bit m_r  [NE][2];

    always #4 clk = ~clk;

    preg_wakeup_sb i_preg_wakeup_sb (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_slot(disp_slot),
        .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
        .disp_dst_valid(disp_dst_valid), .disp_dst(disp_dst),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
        .squash_mask(squash_mask),
        .preg_ready(preg_ready), .entry_valid(entry_valid),
        .entry_ready(entry_ready)
    );

    task automatic idle();
        disp_valid = 0; disp_slot = '0; disp_src_a = '0; disp_src_b = '0;
        disp_dst_valid = 0; disp_dst = '0; cmpl_valid = 0; cmpl_tag = '0;
        squash_mask = '0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NP; i++) m_sb[i] = 0;
        for (int e = 0; e < NE; e++) begin
            m_v[e] = 0;
            for (int s = 0; s < 2; s++) begin m_tag[e][s] = 0; m_r[e][s] = 0; end
        end
    endtask

    // Applies the inputs held across the last rising edge.
    task automatic model_step();
        int ct, dt, sl;
        int st[2];
        bit trk;
        bit nr[2];
        ct  = int'(cmpl_tag);
        dt  = int'(disp_dst);
        sl  = int'(disp_slot);
        st[0] = int'(disp_src_a);
        st[1] = int'(disp_src_b);
        trk = cmpl_valid && ct < NP;
        for (int s = 0; s < 2; s++)
            nr[s] = (st[s] >= NP) || m_sb[st[s] % NP] || (trk && ct == st[s]);
        for (int e = 0; e < NE; e++) begin
            if (squash_mask[e]) m_v[e] = 0;
            else if (m_v[e] && trk)
                for (int s = 0; s < 2; s++) if (m_tag[e][s] == ct) m_r[e][s] = 1;
        end
        if (disp_valid) begin
            m_v[sl] = 1;
            for (int s = 0; s < 2; s++) begin m_tag[sl][s] = st[s]; m_r[sl][s] = nr[s]; end
        end
        if (trk) m_sb[ct] = 1;
        if (disp_valid && disp_dst_valid && dt < NP) m_sb[dt] = 0;
    endtask

    task automatic check_all(string req);
        logic [NP-1:0] e_sb;
        logic [NE-1:0] e_v, e_r;
        for (int i = 0; i < NP; i++) e_sb[i] = m_sb[i];
        for (int e = 0; e < NE; e++) begin
            e_v[e] = m_v[e];
            e_r[e] = m_v[e] && m_r[e][0] && m_r[e][1];
        end
        n_checks += 3;
        if (preg_ready !== e_sb) begin
            n_fail++;
            $display("FAIL %s preg_ready actual %h expected %h", req, preg_ready, e_sb);
        end
        if (entry_valid !== e_v) begin
            n_fail++;
            $display("FAIL %s entry_valid actual %h expected %h", req, entry_valid, e_v);
        end
        if (entry_ready !== e_r) begin
            n_fail++;
            $display("FAIL %s entry_ready actual %h expected %h", req, entry_ready, e_r);
        end
    endtask

    // One clock: inputs set by the caller hold across the edge.
    task automatic cycle(string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(req);
        idle();
    endtask

    task automatic dispatch(int sl, int a, int b, bit dv, int d);
        disp_valid = 1; disp_slot = SW'(sl);
        disp_src_a = TW'(a); disp_src_b = TW'(b);
        disp_dst_valid = dv; disp_dst = TW'(d);
    endtask

    task automatic complete(int t);
        cmpl_valid = 1; cmpl_tag = TW'(t);
    endtask

    initial begin
        idle();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1;
        cycle("R1");

        // R4: completion sets the flag.
        complete(5);
        cycle("R4");
        // R3: src 5 ready at once, src 6 waits; R9 valid next cycle.
        dispatch(0, 5, 6, 1, 7);
        cycle("R3");
        check_all("R9");
        // R4/R6: wakeup makes slot 0 ready.
        complete(6);
        cycle("R6");
        cycle("R6");
        // R2: destination claim clears flag 5.
        dispatch(1, 20, 21, 1, 5);
        cycle("R2");
        // R5: untracked sources ready, untracked completion is ignored.
        dispatch(2, 100, 127, 1, 64);
        complete(70);
        cycle("R5");
        complete(64);
        cycle("R5");
        // R8: same-cycle completion bypass.
        dispatch(3, 9, 127, 0, 0);
        complete(9);
        cycle("R8");
        // R7: squash then completion does not revive.
        dispatch(4, 10, 127, 0, 0);
        cycle("R7");
        squash_mask = 16'h0010;
        cycle("R7");
        complete(10);
        cycle("R7");
        // R2: clear wins over same-cycle set.
        dispatch(5, 127, 127, 1, 11);
        complete(11);
        cycle("R2");
        // R7: dispatch wins over squash of the same slot.
        squash_mask = 16'h0020;
        dispatch(5, 40, 127, 0, 0);
        cycle("R7");
        // R1: reset clears everything again.
        rst_n = 0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        check_all("R1");
        rst_n = 1;
        cycle("R1");

        // Mixed traffic compared against the model every clock.
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 1) == 1) begin
                dispatch($urandom_range(0, NE - 1),
                         ($urandom_range(0, 9) == 0) ? $urandom_range(64, 127) : $urandom_range(0, 15),
                         ($urandom_range(0, 9) == 0) ? $urandom_range(64, 127) : $urandom_range(0, 15),
                         $urandom_range(0, 1) == 1,
                         ($urandom_range(0, 9) == 0) ? $urandom_range(64, 127) : $urandom_range(0, 15));
            end
            if ($urandom_range(0, 2) != 0)
                complete(($urandom_range(0, 9) == 0) ? $urandom_range(64, 127) : $urandom_range(0, 15));
            if ($urandom_range(0, 15) == 0)
                squash_mask = NE'($urandom());
            cycle("R4 R6");
        end
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual %0d cycles expected completion", cyc);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule